// File: doc/BRIEF.md
# Solar Charge and Load Supervisor

This block is the supervisory controller of a panel-to-battery charger. Each cycle that `sampleValid` is high it takes one set of readings: panel voltage, battery voltage, battery current and load current. After 64 sets it forms one averaged set. It then makes one decision for the whole pass. The charger can be charging (panel switch, buck stage and the tracking loop may run), maintaining (the battery is at float level and the power path is off) or waiting (the power path is idle for a fixed number of passes before it decides again).

The load switch is handled on every pass, whatever the charger state. A low battery or a load overcurrent opens the switch. The switch closes again only when the battery rises above a reconnect level that sits above the cutoff. Between the two levels the switch keeps its last setting.

All thresholds are static inputs, in the same units as the readings. Each output moves one clock after the averaged set is ready, so two clock edges after the 64th sample is accepted.

Top module: `solar_supervisor`

## Requirements
- R1: After reset, panelEn, buckEn, mpptEn and loadEn are all low. They stay low until the first complete pass of 64 samples has been averaged.
- R2: Each average is the 64-sample sum shifted right by 6, with the remainder dropped. Outputs change only on a pass boundary, so 63 samples have no effect. Example: battery readings alternating 579/580 average to 579.
- R3: When not waiting or at float, a pass with panel > battery and panel < panelVMax enters charging. In charging, panelEn and buckEn are high.
- R4: In charging, mpptEn is high only when battery voltage < battVMax and battery current < battIMax. Otherwise buckEn stays high and mpptEn is low.
- R5: A pass with battery voltage >= battVFloat, outside the wait state, enters maintenance with panelEn, buckEn and mpptEn low. This takes priority over R3.
- R6: The wait state is entered on a pass that fails the R3 condition, or on a charging pass with battery current < battIMin. Entering it clears buckEn and mpptEn. panelEn is kept unless panel > panelVMax.
- R7: In the wait state, each pass adds one to a pass counter that starts at 0. panelEn drops when the counter exceeds 10, which is on the 11th pass, or at once when panel > panelVMax.
- R8: On the pass where the counter reaches 50, the wait ends with all power-path enables low. Readings in the wait state, other than panel overvoltage, have no effect. The next pass is evaluated afresh by R3 to R6, and the low-current rule applies only in charging.
- R9: On any pass with battery voltage < battCutoff or load current > loadIMax, loadEn goes low.
- R10: loadEn goes high only on a pass with battery voltage > battReconnect and no R9 condition. Between the cutoff and reconnect levels it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One reading set is present this cycle |
| panelVIn | input | 10 | Panel voltage reading |
| battVIn | input | 10 | Battery voltage reading |
| battIIn | input | 10 | Battery current reading |
| loadIIn | input | 10 | Load current reading |
| panelVMax | input | 10 | Panel overvoltage limit |
| battVMax | input | 10 | Battery voltage limit for tracking |
| battVFloat | input | 10 | Battery float level |
| battIMax | input | 10 | Battery current limit for tracking |
| battIMin | input | 10 | Battery current below which charging pauses |
| battCutoff | input | 10 | Load cutoff battery level |
| battReconnect | input | 10 | Load reconnect battery level |
| loadIMax | input | 10 | Load overcurrent limit |
| panelEn | output | 1 | Panel switch enable |
| buckEn | output | 1 | Buck stage enable |
| mpptEn | output | 1 | Tracking loop enable |
| loadEn | output | 1 | Load switch enable |

## Verification
The assertions assume that readings arrive only with `sampleValid`. They also assume the thresholds stay fixed during a pass, and that the reconnect level lies above the cutoff and the float level lies at or below the tracking voltage limit. The stimulus never changes a threshold and sends reading sets only through whole-pass or part-pass tasks, so it stays within these assumptions. The stimulus sets the readings to values that sit exactly at or next to each threshold, including a battery average that lands just below float only because the remainder is dropped.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Decision flags, evaluated on the registered averages.
  typedef struct packed {
    logic chargeOk;   // panel above battery and below panel limit
    logic panelOver;  // panel above panel limit
    logic atFloat;    // battery at or above float level
    logic mpptOk;     // battery voltage and current under their limits
    logic lowCurrent; // battery current under minimum
    logic loadTrip;   // battery under cutoff or load overcurrent
    logic reconnect;  // battery above reconnect level
  } supFlags_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_CHARGE   = 2'd1,
    ST_MAINTAIN = 2'd2,
    ST_WAIT     = 2'd3
  } supState_t;

  localparam int NUM_CHAN = 4;
  localparam int CH_PANEL_V = 0;
  localparam int CH_BATT_V  = 1;
  localparam int CH_BATT_I  = 2;
  localparam int CH_LOAD_I  = 3;

endpackage

// File: rtl/sup_accum.sv
module sup_accum #(
  parameter int SAMPLE_W = 10,
  parameter int AVG_LOG2 = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                add,
  input  logic                last,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W-1:0] avg
);
  localparam int ACC_W = SAMPLE_W + AVG_LOG2;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;

  assign sum = acc + ACC_W'(sample);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      avg <= '0;
    end else if (add) begin
      if (last) begin
        acc <= '0;
        avg <= sum[ACC_W-1:AVG_LOG2];
      end else begin
        acc <= sum;
      end
    end
  end

endmodule

// File: rtl/sup_datapath.sv
module sup_datapath
  import sup_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int AVG_LOG2 = 6
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               sampleValid,
  input  logic [NUM_CHAN-1:0][SAMPLE_W-1:0]  chanIn,
  input  logic [SAMPLE_W-1:0]                panelVMax,
  input  logic [SAMPLE_W-1:0]                battVMax,
  input  logic [SAMPLE_W-1:0]                battVFloat,
  input  logic [SAMPLE_W-1:0]                battIMax,
  input  logic [SAMPLE_W-1:0]                battIMin,
  input  logic [SAMPLE_W-1:0]                battCutoff,
  input  logic [SAMPLE_W-1:0]                battReconnect,
  input  logic [SAMPLE_W-1:0]                loadIMax,
  output logic                               passDone,
  output supFlags_t                          flags
);
  logic [AVG_LOG2-1:0]                sampleCnt;
  logic                               lastSample;
  logic [NUM_CHAN-1:0][SAMPLE_W-1:0]  avg;

  assign lastSample = (sampleCnt == '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
      passDone  <= 1'b0;
    end else begin
      passDone <= sampleValid && lastSample;
      if (sampleValid) sampleCnt <= sampleCnt + 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    sup_accum #(.SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2)) i_accum (
      .clk    (clk),
      .rstN   (rstN),
      .add    (sampleValid),
      .last   (lastSample),
      .sample (chanIn[c]),
      .avg    (avg[c])
    );
  end

  always_comb begin
    flags.chargeOk   = (avg[CH_PANEL_V] > avg[CH_BATT_V]) && (avg[CH_PANEL_V] < panelVMax);
    flags.panelOver  = avg[CH_PANEL_V] > panelVMax;
    flags.atFloat    = avg[CH_BATT_V] >= battVFloat;
    flags.mpptOk     = (avg[CH_BATT_V] < battVMax) && (avg[CH_BATT_I] < battIMax);
    flags.lowCurrent = avg[CH_BATT_I] < battIMin;
    flags.loadTrip   = (avg[CH_BATT_V] < battCutoff) || (avg[CH_LOAD_I] > loadIMax);
    flags.reconnect  = avg[CH_BATT_V] > battReconnect;
  end

  // R2: a pass completes only on an accepted sample
  p_pass_needs_sample_r2: assert property (@(posedge clk) disable iff (!rstN)
    passDone |-> $past(sampleValid));

  // R2: passes never come back to back
  p_pass_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    passDone |=> !passDone);

endmodule

// File: rtl/sup_control.sv
module sup_control
  import sup_pkg::*;
#(
  parameter int WAIT_PASSES   = 50,
  parameter int WAIT_PANEL_OFF = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      passDone,
  input  supFlags_t flags,
  output logic      panelEn,
  output logic      buckEn,
  output logic      mpptEn,
  output logic      loadEn
);
  localparam int WCW = $clog2(WAIT_PASSES + 1);
  localparam logic [WCW-1:0] WAIT_END = WCW'(WAIT_PASSES);
  localparam logic [WCW-1:0] WAIT_OFF = WCW'(WAIT_PANEL_OFF);

  supState_t      state;
  logic [WCW-1:0] waitCnt;
  logic [WCW-1:0] nextCnt;

  assign nextCnt = waitCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      panelEn <= 1'b0;
      buckEn  <= 1'b0;
      mpptEn  <= 1'b0;
    end else if (passDone) begin
      if (state == ST_WAIT) begin
        buckEn  <= 1'b0;
        mpptEn  <= 1'b0;
        if (flags.panelOver || (nextCnt > WAIT_OFF)) panelEn <= 1'b0;
        if (nextCnt == WAIT_END) begin
          state   <= ST_IDLE;
          waitCnt <= '0;
          panelEn <= 1'b0;
        end else begin
          waitCnt <= nextCnt;
        end
      end else if (flags.atFloat) begin
        state   <= ST_MAINTAIN;
        panelEn <= 1'b0;
        buckEn  <= 1'b0;
        mpptEn  <= 1'b0;
      end else if (!flags.chargeOk || (state == ST_CHARGE && flags.lowCurrent)) begin
        state   <= ST_WAIT;
        waitCnt <= '0;
        buckEn  <= 1'b0;
        mpptEn  <= 1'b0;
        if (flags.panelOver) panelEn <= 1'b0;
      end else begin
        state   <= ST_CHARGE;
        panelEn <= 1'b1;
        buckEn  <= 1'b1;
        mpptEn  <= flags.mpptOk;
      end
    end
  end

  // Load management runs on every pass, independent of charger state.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadEn <= 1'b0;
    end else if (passDone) begin
      if (flags.loadTrip)       loadEn <= 1'b0;
      else if (flags.reconnect) loadEn <= 1'b1;
    end
  end

  p_quiet_between_r2: assert property (@(posedge clk) disable iff (!rstN)
    !passDone |=> $stable({panelEn, buckEn, mpptEn, loadEn}));

  p_buck_needs_panel_r6: assert property (@(posedge clk) disable iff (!rstN)
    buckEn |-> panelEn);

  p_mppt_needs_buck_r4: assert property (@(posedge clk) disable iff (!rstN)
    mpptEn |-> buckEn);

  p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt < WAIT_END);

  p_trip_r9: assert property (@(posedge clk) disable iff (!rstN)
    passDone && flags.loadTrip |=> !loadEn);

  p_reconnect_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadEn) |-> $past(passDone && flags.reconnect && !flags.loadTrip));

  p_float_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    passDone && flags.atFloat && state != ST_WAIT |=> !panelEn && !buckEn);

endmodule

// File: rtl/solar_supervisor.sv
module solar_supervisor
  import sup_pkg::*;
#(
  parameter int SAMPLE_W       = 10,
  parameter int AVG_LOG2       = 6,
  parameter int WAIT_PASSES    = 50,
  parameter int WAIT_PANEL_OFF = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] panelVIn,
  input  logic [SAMPLE_W-1:0] battVIn,
  input  logic [SAMPLE_W-1:0] battIIn,
  input  logic [SAMPLE_W-1:0] loadIIn,
  input  logic [SAMPLE_W-1:0] panelVMax,
  input  logic [SAMPLE_W-1:0] battVMax,
  input  logic [SAMPLE_W-1:0] battVFloat,
  input  logic [SAMPLE_W-1:0] battIMax,
  input  logic [SAMPLE_W-1:0] battIMin,
  input  logic [SAMPLE_W-1:0] battCutoff,
  input  logic [SAMPLE_W-1:0] battReconnect,
  input  logic [SAMPLE_W-1:0] loadIMax,
  output logic                panelEn,
  output logic                buckEn,
  output logic                mpptEn,
  output logic                loadEn
);
  logic [NUM_CHAN-1:0][SAMPLE_W-1:0] chanIn;
  logic                              passDone;
  supFlags_t                         flags;

  always_comb begin
    chanIn[CH_PANEL_V] = panelVIn;
    chanIn[CH_BATT_V]  = battVIn;
    chanIn[CH_BATT_I]  = battIIn;
    chanIn[CH_LOAD_I]  = loadIIn;
  end

  sup_datapath #(.SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2)) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .sampleValid   (sampleValid),
    .chanIn        (chanIn),
    .panelVMax     (panelVMax),
    .battVMax      (battVMax),
    .battVFloat    (battVFloat),
    .battIMax      (battIMax),
    .battIMin      (battIMin),
    .battCutoff    (battCutoff),
    .battReconnect (battReconnect),
    .loadIMax      (loadIMax),
    .passDone      (passDone),
    .flags         (flags)
  );

  sup_control #(.WAIT_PASSES(WAIT_PASSES), .WAIT_PANEL_OFF(WAIT_PANEL_OFF)) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .passDone (passDone),
    .flags    (flags),
    .panelEn  (panelEn),
    .buckEn   (buckEn),
    .mpptEn   (mpptEn),
    .loadEn   (loadEn)
  );

endmodule

// File: tb/test_solar_supervisor.sv
module test_solar_supervisor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [9:0] panelVIn = '0, battVIn = '0, battIIn = '0, loadIIn = '0;
  logic [9:0] panelVMax = 10'd800, battVMax = 10'd600, battVFloat = 10'd580;
  logic [9:0] battIMax = 10'd900, battIMin = 10'd20, battCutoff = 10'd400;
  logic [9:0] battReconnect = 10'd450, loadIMax = 10'd700;
  logic panelEn, buckEn, mpptEn, loadEn;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  solar_supervisor i_solar_supervisor (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .panelVIn(panelVIn), .battVIn(battVIn), .battIIn(battIIn), .loadIIn(loadIIn),
    .panelVMax(panelVMax), .battVMax(battVMax), .battVFloat(battVFloat),
    .battIMax(battIMax), .battIMin(battIMin), .battCutoff(battCutoff),
    .battReconnect(battReconnect), .loadIMax(loadIMax),
    .panelEn(panelEn), .buckEn(buckEn), .mpptEn(mpptEn), .loadEn(loadEn)
  );

  task automatic expect4(input string req, input logic p, input logic b,
                         input logic m, input logic l);
    checks++;
    if ({panelEn, buckEn, mpptEn, loadEn} !== {p, b, m, l}) begin
      errors++;
      $display("FAIL %s: panel/buck/mppt/load actual=%b%b%b%b expected=%b%b%b%b",
               req, panelEn, buckEn, mpptEn, loadEn, p, b, m, l);
    end
  endtask

  // n samples; battery alternates by +alt on odd samples
  task automatic sendSamples(input int n, input int p, input int b, input int bi,
                             input int li, input int alt);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      panelVIn = 10'(p);
      battVIn  = 10'(b + ((i % 2) * alt));
      battIIn  = 10'(bi);
      loadIIn  = 10'(li);
    end
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendPass(input int p, input int b, input int bi, input int li);
    sendSamples(64, p, b, bi, li, 0);
  endtask

  task automatic t_reset;
    expect4("R1", 0, 0, 0, 0);
  endtask

  task automatic t_partial_then_charge;
    sendSamples(63, 700, 500, 100, 100, 0);
    expect4("R2", 0, 0, 0, 0);
    sendSamples(1, 700, 500, 100, 100, 0);
    expect4("R3", 1, 1, 1, 1);
  endtask

  task automatic t_mppt_limit;
    sendPass(700, 500, 950, 100);
    expect4("R4", 1, 1, 0, 1);
    sendPass(700, 500, 100, 100);
    expect4("R4", 1, 1, 1, 1);
  endtask

  task automatic t_load;
    sendPass(700, 420, 100, 100);
    expect4("R10", 1, 1, 1, 1);
    sendPass(700, 390, 100, 100);
    expect4("R9", 1, 1, 1, 0);
    sendPass(700, 420, 100, 100);
    expect4("R10", 1, 1, 1, 0);
    sendPass(700, 450, 100, 100);
    expect4("R10", 1, 1, 1, 0);
    sendPass(700, 460, 100, 100);
    expect4("R10", 1, 1, 1, 1);
    sendPass(700, 460, 100, 750);
    expect4("R9", 1, 1, 1, 0);
    sendPass(700, 500, 100, 100);
    expect4("R10", 1, 1, 1, 1);
  endtask

  task automatic t_float;
    sendSamples(64, 700, 579, 100, 100, 1);
    expect4("R2", 1, 1, 1, 1);
    sendPass(700, 580, 100, 100);
    expect4("R5", 0, 0, 0, 1);
    sendPass(700, 500, 100, 100);
    expect4("R3", 1, 1, 1, 1);
  endtask

  task automatic t_wait_low_current;
    sendPass(700, 500, 10, 100);
    expect4("R6", 1, 0, 0, 1);
    for (int k = 1; k <= 10; k++) sendPass(700, 500, 10, 100);
    expect4("R7", 1, 0, 0, 1);
    sendPass(700, 500, 10, 100);
    expect4("R7", 0, 0, 0, 1);
    for (int k = 12; k <= 49; k++) sendPass(700, 500, 100, 100);
    expect4("R8", 0, 0, 0, 1);
    sendPass(700, 500, 100, 100);
    expect4("R8", 0, 0, 0, 1);
    sendPass(700, 500, 10, 100);
    expect4("R8", 1, 1, 1, 1);
  endtask

  task automatic t_wait_overvoltage;
    sendPass(850, 500, 100, 100);
    expect4("R7", 0, 0, 0, 1);
    for (int k = 1; k <= 49; k++) sendPass(700, 500, 100, 100);
    expect4("R8", 0, 0, 0, 1);
    sendPass(700, 500, 100, 100);
    sendPass(700, 500, 100, 100);
    expect4("R8", 1, 1, 1, 1);
    sendPass(400, 500, 100, 100);
    expect4("R6", 1, 0, 0, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_partial_then_charge();
    t_mppt_limit();
    t_load();
    t_float();
    t_wait_low_current();
    t_wait_overvoltage();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule